// File: doc/BRIEF.md
# Cascadable Synchronous Load Counter

This block is a synchronous binary up-counter built from narrow stages that chain into a wider count. Each stage registers a small count on the rising clock edge. It has a synchronous clear, a synchronous parallel load, and two active-high count enables. One of the two enables also qualifies the stage's terminal-count flag. Because of that gating, the flag of one stage can drive the gating enable of the next. Carries then reach higher stages without any extra register.

The top module wires a parameterised number of stages into one wide counter. All stages share the clock, clear, load and data lines. A global run enable feeds the ungated enable of every stage. The global carry-in enable feeds the gating enable of the lowest stage, and each stage's terminal-count flag feeds the gating enable of the stage above it. Inside a stage, a bit flips only when every lower bit is 1 and the stage is counting.

Top module: `sync_count_chain`

## Requirements
- R1: On a rising edge with `clr_n` low, the whole count becomes zero, whatever `load_n`, both enables and `din` are.
- R2: On a rising edge with `clr_n` high and `load_n` low, `count` takes the value of `din`, whatever the enables are.
- R3: Within a stage, with clear and load inactive and both stage enables high, the stage count goes up by one on the rising edge and wraps from all ones to zero.
- R4: With clear and load inactive and either `run_en` or `carry_en` low, `count` keeps its value.
- R5: When `carry_en` is low, `term_cnt` is low.
- R6: A stage's terminal-count flag is high exactly when its count is all ones and its gating enable is high. The flag is combinational and appears in the same cycle.
- R7: With clear and load inactive and `run_en` and `carry_en` both high, the full `count` goes up by one on each edge. Carries cross stage boundaries (0x00FF to 0x0100), and the count wraps from 0xFFFF to 0x0000.
- R8: `term_cnt` is high exactly when `count` is all ones and `carry_en` is high.
- R9: With `run_en` low and `carry_en` high, no stage advances, even where a lower stage's terminal-count flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| run_en | input | 1 | Ungated count enable shared by all stages |
| carry_en | input | 1 | Gating enable of the lowest stage; also qualifies term_cnt |
| din | input | STAGE_W*STAGES (16) | Parallel load value |
| count | output | STAGE_W*STAGES (16) | Current count |
| term_cnt | output | 1 | Terminal count of the top stage |

## Verification
The bench builds the block with the default four stages of four bits, which gives a 16-bit count. At that width the carry chain crosses three stage boundaries. Loads placed just below 0x00FF, 0x0FFF and 0xFFFF bring every boundary carry and the full wraparound within a few cycles. A behavioural integer model runs next to the design, so long stretches of mixed clear, load, count and hold cycles can be compared every clock.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    // Action taken by a stage on the next rising edge, in priority order.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_COUNT = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_CLEAR = 2'd3
    } act_e;

    // Clear beats load, load beats count, count needs both enables.
    function automatic act_e pick_action(input logic clr_n,
                                         input logic load_n,
                                         input logic en_p,
                                         input logic en_t);
        act_e a;
        if (!clr_n)
            a = ACT_CLEAR;
        else if (!load_n)
            a = ACT_LOAD;
        else if (en_p && en_t)
            a = ACT_COUNT;
        else
            a = ACT_HOLD;
        return a;
    endfunction

endpackage

// File: rtl/toggle_net.sv
// Per-bit flip enables: bit k flips only when counting and every lower bit is 1.
module toggle_net #(
    parameter int W = 4
) (
    input  logic         run,
    input  logic [W-1:0] cur,
    output logic [W-1:0] flip
);
    logic [W-1:0] chain;

    assign chain[0] = run;

    genvar k;
    generate
        for (k = 1; k < W; k++) begin : g_chain
            assign chain[k] = chain[k-1] & cur[k-1];
        end
    endgenerate

    assign flip = chain;

endmodule

// File: rtl/count_stage.sv
module count_stage
    import cnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load_n,
    input  logic         en_p,
    input  logic         en_t,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         tc
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } stage_t;

    stage_t       st_d, st_q;
    act_e         act;
    logic [W-1:0] flip;

    toggle_net #(.W(W)) u_tog (
        .run  (en_p & en_t),
        .cur  (st_q.cnt),
        .flip (flip)
    );

    always_comb begin
        act  = pick_action(clr_n, load_n, en_p, en_t);
        st_d = st_q;
        case (act)
            ACT_CLEAR: st_d.cnt = '0;
            ACT_LOAD:  st_d.cnt = din;
            ACT_COUNT: st_d.cnt = st_q.cnt ^ flip;
            default:   st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q  = st_q.cnt;
    assign tc = en_t & (&st_q.cnt);

    // Checking starts once a clear has been seen.
    logic seen_clr_q = 1'b0;
    always_ff @(posedge clk) begin
        if (!clr_n) seen_clr_q <= 1'b1;
    end

    p_clear_r1: assert property (@(posedge clk) disable iff (!seen_clr_q)
        !clr_n |=> (q == '0));

    p_load_r2: assert property (@(posedge clk) disable iff (!seen_clr_q)
        (clr_n && !load_n) |=> (q == $past(din)));

    p_incr_r3: assert property (@(posedge clk) disable iff (!seen_clr_q)
        (clr_n && load_n && en_p && en_t) |=> (q == W'($past(q) + 1'b1)));

    p_hold_r4: assert property (@(posedge clk) disable iff (!seen_clr_q)
        (clr_n && load_n && !(en_p && en_t)) |=> $stable(q));

    p_tc_gate_r5: assert property (@(posedge clk) disable iff (!seen_clr_q)
        !en_t |-> !tc);

    p_tc_full_r6: assert property (@(posedge clk) disable iff (!seen_clr_q)
        (en_t && (q == {W{1'b1}})) |-> tc);

endmodule

// File: rtl/sync_count_chain.sv
module sync_count_chain #(
    parameter int STAGE_W = 4,
    parameter int STAGES  = 4
) (
    input  logic                         clk,
    input  logic                         clr_n,
    input  logic                         load_n,
    input  logic                         run_en,
    input  logic                         carry_en,
    input  logic [STAGE_W*STAGES-1:0]    din,
    output logic [STAGE_W*STAGES-1:0]    count,
    output logic                         term_cnt
);
    localparam int TOTAL_W = STAGE_W * STAGES;

    logic [STAGES-1:0] tc_w;
    logic [STAGES-1:0] gate_w;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                assign gate_w[s] = carry_en;
            end else begin : g_upper
                assign gate_w[s] = tc_w[s-1];
            end

            count_stage #(.W(STAGE_W)) u_stage (
                .clk    (clk),
                .clr_n  (clr_n),
                .load_n (load_n),
                .en_p   (run_en),
                .en_t   (gate_w[s]),
                .din    (din[s*STAGE_W +: STAGE_W]),
                .q      (count[s*STAGE_W +: STAGE_W]),
                .tc     (tc_w[s])
            );
        end
    endgenerate

    assign term_cnt = tc_w[STAGES-1];

    logic seen_clr_q = 1'b0;
    always_ff @(posedge clk) begin
        if (!clr_n) seen_clr_q <= 1'b1;
    end

    p_wide_incr_r7: assert property (@(posedge clk) disable iff (!seen_clr_q)
        (clr_n && load_n && run_en && carry_en)
            |=> (count == TOTAL_W'($past(count) + 1'b1)));

    p_term_r8: assert property (@(posedge clk) disable iff (!seen_clr_q)
        term_cnt |-> (carry_en && (&count)));

    p_run_low_r9: assert property (@(posedge clk) disable iff (!seen_clr_q)
        (clr_n && load_n && !run_en) |=> $stable(count));

endmodule

// File: tb/sync_count_chain_tb.sv
module sync_count_chain_tb;

    localparam int SW = 4;
    localparam int NS = 4;
    localparam int TW = SW * NS;

    logic          clk = 1'b0;
    logic          clr_n = 1'b1;
    logic          load_n = 1'b1;
    logic          run_en = 1'b0;
    logic          carry_en = 1'b0;
    logic [TW-1:0] din = '0;
    logic [TW-1:0] count;
    logic          term_cnt;

    int checks = 0;
    int errors = 0;
    int ref_cnt = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sync_count_chain #(.STAGE_W(SW), .STAGES(NS)) u_dut (
        .clk      (clk),
        .clr_n    (clr_n),
        .load_n   (load_n),
        .run_en   (run_en),
        .carry_en (carry_en),
        .din      (din),
        .count    (count),
        .term_cnt (term_cnt)
    );

    function automatic bit exp_tc();
        return (ref_cnt == 32'hFFFF) && carry_en;
    endfunction

    task automatic check_now(input string tag);
        bit etc;
        etc = exp_tc();
        checks++;
        if (count !== ref_cnt[TW-1:0]) begin
            errors++;
            $display("FAIL %s count actual %h expected %h", tag, count, ref_cnt[TW-1:0]);
        end
        checks++;
        if (term_cnt !== etc) begin
            errors++;
            $display("FAIL %s term_cnt actual %b expected %b", tag, term_cnt, etc);
        end
    endtask

    // Drive at negedge, let one rising edge pass, update model, compare.
    task automatic step(input logic c, input logic l, input logic p,
                        input logic t, input logic [TW-1:0] d,
                        input string tag);
        clr_n = c; load_n = l; run_en = p; carry_en = t; din = d;
        @(posedge clk);
        if (!c)          ref_cnt = 0;
        else if (!l)     ref_cnt = int'(d);
        else if (p && t) ref_cnt = (ref_cnt + 1) & 32'hFFFF;
        @(negedge clk);
        check_now(tag);
    endtask

    initial begin
        @(negedge clk);
        // R1: clear with every other input active
        step(1'b0, 1'b0, 1'b1, 1'b1, 16'hABCD, "R1");
        step(1'b0, 1'b1, 1'b1, 1'b1, 16'h1234, "R1");
        // R2: load wins over counting
        step(1'b1, 1'b0, 1'b1, 1'b1, 16'h00FD, "R2");
        // R3 low nibble wrap and R7 carry into second stage
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1, 1'b1, '0, "R7");
        // R9: lower stage full, run_en low, carry_en high: nothing moves
        step(1'b1, 1'b0, 1'b0, 1'b0, 16'h00FF, "R2");
        step(1'b1, 1'b1, 1'b0, 1'b1, '0, "R9");
        step(1'b1, 1'b1, 1'b0, 1'b1, '0, "R9");
        step(1'b1, 1'b1, 1'b1, 1'b1, '0, "R3");
        // Carry across third boundary
        step(1'b1, 1'b0, 1'b0, 1'b0, 16'h0FFE, "R2");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1'b1, '0, "R7");
        // Full wrap; term_cnt at FFFF with carry_en high
        step(1'b1, 1'b0, 1'b1, 1'b0, 16'hFFFD, "R2");
        step(1'b1, 1'b1, 1'b1, 1'b1, '0, "R7");
        step(1'b1, 1'b1, 1'b1, 1'b1, '0, "R6");
        step(1'b1, 1'b1, 1'b0, 1'b1, '0, "R8");
        // R5: carry_en low forces term_cnt low and count holds (R4)
        step(1'b1, 1'b1, 1'b1, 1'b0, '0, "R5");
        step(1'b1, 1'b1, 1'b0, 1'b0, '0, "R4");
        step(1'b1, 1'b1, 1'b1, 1'b1, '0, "R7");
        // Clear beats load
        step(1'b0, 1'b0, 1'b0, 1'b0, 16'h5555, "R1");
        // Mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int r;
            logic c, l, p, t;
            logic [TW-1:0] d;
            r = int'($urandom_range(0, 99));
            c = (r >= 2);
            l = !(r >= 2 && r < 6);
            p = ($urandom_range(0, 9) != 0);
            t = ($urandom_range(0, 9) != 0);
            d = ($urandom_range(0, 1) == 1) ? 16'hFFF8 + TW'($urandom_range(0, 7))
                                           : TW'($urandom);
            if (!c)           step(c, l, p, t, d, "R1");
            else if (!l)      step(c, l, p, t, d, "R2");
            else if (p && t)  step(c, l, p, t, d, "R7");
            else              step(c, l, p, t, d, "R4");
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule